// File: doc/BRIEF.md
# Filtered Quadrature Position Counter

This block decodes one quadrature encoder channel. The encoder's A, B and index (Z) lines come from outside the chip. The block resynchronises each line to the 40 MHz sampling clock and passes it through its own glitch filter. The filter lets a new level through only after that level has been seen on seven consecutive samples, so at 25 ns per sample any pulse shorter than 175 ns is dropped. The filtered A and B lines drive a 4x decoder. Each edge on either line moves a 14-bit position counter up or down by one, and the counter wraps.

Software reads the position through a latch strobe. One strobe copies the running count into a holding register, and that value stays put until the next strobe. Each channel has its own strobe, so channels can be latched at different times. The host takes the difference between two latched values modulo 2^14, which gives it up to 8191 counts of travel between reads.

The host can arm index capture. While armed, the first rising edge of the filtered Z line copies the count into an index register, raises an index-seen flag and disarms the block. If A and B change in the same filtered sample, the block cannot tell the direction. It leaves the count alone and raises an error flag that stays set.

Top module: `quad_pos_counter`

## Requirements
- R1: While reset is held, and on leaving it, both registers (latched count and index count) read 0. The index-seen, armed and error flags also read 0.
- R2: Each raw input passes through a two-stage synchronizer and then a filter. The filter's output takes a new level only after that level has been sampled on 7 consecutive clocks. A pulse of 6 samples or fewer changes neither the count nor the index state.
- R3: The count moves by one on each filtered edge of A or B. An A edge counts up when the new A differs from the new B and down otherwise. A B edge counts up when the new A equals the new B and down otherwise. So the sequence AB = 00, 10, 11, 01 counts up.
- R4: If filtered A and filtered B both change on the same clock, the count is unchanged and the error flag is set. The flag stays set until reset.
- R5: When latch_req is high at a clock edge, the current count is copied to latch_count. At any other edge, latch_count holds its value.
- R6: A pulse on idx_arm_set sets the armed flag and clears index-seen. While armed, a rising edge of filtered Z copies the count into idx_count, sets index-seen and clears armed.
- R7: The count is 14 bits wide and wraps. One step down from 0 gives 16383. The difference of two latched values modulo 2^14 recovers a travel of 8191 counts.
- R8: A falling edge of filtered Z does nothing. A rising edge while not armed also does nothing: idx_count, index-seen and armed keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock (40 MHz nominal) |
| rst_n | input | 1 | Asynchronous active-low reset |
| qa_raw | input | 1 | Raw encoder A line, may be asynchronous |
| qb_raw | input | 1 | Raw encoder B line, may be asynchronous |
| qz_raw | input | 1 | Raw encoder index line, may be asynchronous |
| latch_req | input | 1 | One-cycle strobe that copies the count into latch_count |
| idx_arm_set | input | 1 | One-cycle strobe that arms index capture and clears index-seen |
| latch_count | output | 14 | Count captured at the last latch strobe |
| idx_count | output | 14 | Count captured at the last armed index rising edge |
| idx_seen | output | 1 | An armed index edge has been captured |
| idx_armed | output | 1 | Index capture is armed |
| quad_err | output | 1 | Sticky flag for an invalid A/B transition |

## Verification
The assertions expect latch_req and idx_arm_set to be synchronous to clk and sampled cleanly at the edge. The raw encoder lines may change at any time, because they pass through the synchronizer before any checked state. The stimulus changes every input half a period away from the rising edge. Apart from deliberate glitches of six samples, it holds each quadrature level for at least seven samples. It leaves enough settling cycles after a step before it strobes a latch or raises Z, so every captured value is one the requirements fix exactly.

// File: rtl/qpc_pkg.sv
package qpc_pkg;

  localparam int IN_A = 0;
  localparam int IN_B = 1;
  localparam int IN_Z = 2;
  localparam int N_IN = 3;

  typedef enum logic [1:0] {
    STEP_HOLD = 2'd0,
    STEP_INC  = 2'd1,
    STEP_DEC  = 2'd2,
    STEP_BAD  = 2'd3
  } step_t;

  // Sort one A/B transition between two filtered samples.
  function automatic step_t classify(input logic a_old, input logic b_old,
                                     input logic a_new, input logic b_new);
    logic   ca;
    logic   cb;
    step_t  res;
    ca  = a_old ^ a_new;
    cb  = b_old ^ b_new;
    res = STEP_HOLD;
    if (ca && cb)  res = STEP_BAD;
    else if (ca)   res = (a_new != b_new) ? STEP_INC : STEP_DEC;
    else if (cb)   res = (a_new == b_new) ? STEP_INC : STEP_DEC;
    return res;
  endfunction

endpackage

// File: rtl/qpc_sync_filter.sv
module qpc_sync_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic sync_o,
  output logic filt_o
);

  localparam int CW = (FILT_LEN > 2) ? $clog2(FILT_LEN) : 1;
  localparam logic [CW-1:0] LAST = CW'(FILT_LEN - 1);

  logic [SYNC_STAGES-1:0] sh;
  logic [CW-1:0]          run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[SYNC_STAGES-2:0], din};
  end

  assign sync_o = sh[SYNC_STAGES-1];

  // Count samples that disagree with the output; any agreeing sample restarts the run.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run    <= '0;
      filt_o <= 1'b0;
    end else if (sync_o == filt_o) begin
      run <= '0;
    end else if (run == LAST) begin
      run    <= '0;
      filt_o <= sync_o;
    end else begin
      run <= run + 1'b1;
    end
  end

endmodule

// File: rtl/qpc_step_counter.sv
module qpc_step_counter
  import qpc_pkg::*;
#(
  parameter int CNT_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             a_f,
  input  logic             b_f,
  output logic [CNT_W-1:0] pos,
  output logic             err_o
);

  logic  a_d;
  logic  b_d;
  step_t step;

  assign step = classify(a_d, b_d, a_f, b_f);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_d   <= 1'b0;
      b_d   <= 1'b0;
      pos   <= '0;
      err_o <= 1'b0;
    end else begin
      a_d <= a_f;
      b_d <= b_f;
      case (step)
        STEP_INC: pos   <= pos + CNT_W'(1);
        STEP_DEC: pos   <= pos - CNT_W'(1);
        STEP_BAD: err_o <= 1'b1;
        default:  ;
      endcase
    end
  end

endmodule

// File: rtl/qpc_index_capture.sv
module qpc_index_capture #(
  parameter int CNT_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             z_f,
  input  logic             arm_set,
  input  logic [CNT_W-1:0] pos,
  output logic [CNT_W-1:0] idx_count,
  output logic             seen,
  output logic             armed
);

  logic z_d;
  logic z_rise;

  assign z_rise = z_f & ~z_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      z_d       <= 1'b0;
      idx_count <= '0;
      seen      <= 1'b0;
      armed     <= 1'b0;
    end else begin
      z_d <= z_f;
      if (arm_set) begin
        armed <= 1'b1;
        seen  <= 1'b0;
      end else if (armed && z_rise) begin
        idx_count <= pos;
        seen      <= 1'b1;
        armed     <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/quad_pos_counter.sv
module quad_pos_counter
  import qpc_pkg::*;
#(
  parameter int CNT_W       = 14,
  parameter int FILT_LEN    = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             qa_raw,
  input  logic             qb_raw,
  input  logic             qz_raw,
  input  logic             latch_req,
  input  logic             idx_arm_set,
  output logic [CNT_W-1:0] latch_count,
  output logic [CNT_W-1:0] idx_count,
  output logic             idx_seen,
  output logic             idx_armed,
  output logic             quad_err
);

  logic [N_IN-1:0]  raw_vec;
  logic [N_IN-1:0]  sync_vec;
  logic [N_IN-1:0]  filt_vec;
  logic [CNT_W-1:0] pos_count;

  assign raw_vec[IN_A] = qa_raw;
  assign raw_vec[IN_B] = qb_raw;
  assign raw_vec[IN_Z] = qz_raw;

  for (genvar i = 0; i < N_IN; i++) begin : g_in
    qpc_sync_filter #(
      .SYNC_STAGES(SYNC_STAGES),
      .FILT_LEN   (FILT_LEN)
    ) u_filt (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (raw_vec[i]),
      .sync_o(sync_vec[i]),
      .filt_o(filt_vec[i])
    );
  end

  qpc_step_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk  (clk),
    .rst_n(rst_n),
    .a_f  (filt_vec[IN_A]),
    .b_f  (filt_vec[IN_B]),
    .pos  (pos_count),
    .err_o(quad_err)
  );

  qpc_index_capture #(.CNT_W(CNT_W)) u_idx (
    .clk      (clk),
    .rst_n    (rst_n),
    .z_f      (filt_vec[IN_Z]),
    .arm_set  (idx_arm_set),
    .pos      (pos_count),
    .idx_count(idx_count),
    .seen     (idx_seen),
    .armed    (idx_armed)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         latch_count <= '0;
    else if (latch_req) latch_count <= pos_count;
  end

endmodule

// File: rtl/quad_pos_counter_chk.sv
module quad_pos_counter_chk #(
  parameter int CNT_W = 14
) (
  input logic             clk,
  input logic             rst_n,
  input logic             latch_req,
  input logic             idx_arm_set,
  input logic [CNT_W-1:0] latch_count,
  input logic             idx_seen,
  input logic             idx_armed,
  input logic             quad_err,
  input logic [CNT_W-1:0] pos_count,
  input logic             sync_a,
  input logic             filt_a
);

  logic [CNT_W-1:0] pos_q;
  logic [CNT_W-1:0] delta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pos_q <= '0;
    else        pos_q <= pos_count;
  end

  assign delta = pos_count - pos_q;

  // R2: the filtered level only ever moves to the level it was sampling
  a_r2_filter_follows: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(filt_a) |-> (filt_a == $past(sync_a)));

  // R3: the count moves by at most one per clock
  a_r3_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    (delta == '0) || (delta == CNT_W'(1)) || (delta == {CNT_W{1'b1}}));

  // R4: the error flag never falls once raised
  a_r4_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    quad_err |=> quad_err);

  // R5: without a strobe the latched value holds
  a_r5_latch_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !latch_req |=> $stable(latch_count));

  // R5: a strobe takes the running count
  a_r5_latch_take: assert property (@(posedge clk) disable iff (!rst_n)
    latch_req |=> (latch_count == $past(pos_count)));

  // R6: a capture always disarms
  a_r6_seen_disarms: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(idx_seen) |-> !idx_armed);

  // R6: arming clears the seen flag
  a_r6_arm_effect: assert property (@(posedge clk) disable iff (!rst_n)
    idx_arm_set |=> (idx_armed && !idx_seen));

  // R8: seen holds until the next arm strobe
  a_r8_seen_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (idx_seen && !idx_arm_set) |=> idx_seen);

endmodule

bind quad_pos_counter quad_pos_counter_chk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .latch_req  (latch_req),
  .idx_arm_set(idx_arm_set),
  .latch_count(latch_count),
  .idx_seen   (idx_seen),
  .idx_armed  (idx_armed),
  .quad_err   (quad_err),
  .pos_count  (pos_count),
  .sync_a     (sync_vec[0]),
  .filt_a     (filt_vec[0])
);

// File: tb/quad_pos_counter_bench.sv
`timescale 1ns/1ps
module quad_pos_counter_bench;

  localparam int W    = 14;
  localparam int MASK = 16383;
  localparam int FL   = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic qa_raw = 1'b0, qb_raw = 1'b0, qz_raw = 1'b0;
  logic latch_req = 1'b0, idx_arm_set = 1'b0;
  logic [W-1:0] latch_count, idx_count;
  logic idx_seen, idx_armed, quad_err;

  always #10 clk = ~clk;

  quad_pos_counter u_quad_pos_counter (
    .clk(clk), .rst_n(rst_n), .qa_raw(qa_raw), .qb_raw(qb_raw), .qz_raw(qz_raw),
    .latch_req(latch_req), .idx_arm_set(idx_arm_set), .latch_count(latch_count),
    .idx_count(idx_count), .idx_seen(idx_seen), .idx_armed(idx_armed), .quad_err(quad_err)
  );

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // ---------------- behavioural reference, stepped on every rising edge
  int m_s1[3], m_s2[3], m_f[3], m_run[3];
  int m_ad, m_bd, m_zd, m_cnt, m_err, m_armed, m_seen, m_idx, m_latch;
  bit m_live = 1'b0;

  always @(posedge clk) begin
    int raw[3];
    raw[0] = qa_raw; raw[1] = qb_raw; raw[2] = qz_raw;
    if (!rst_n) begin
      for (int i = 0; i < 3; i++) begin m_s1[i] = 0; m_s2[i] = 0; m_f[i] = 0; m_run[i] = 0; end
      m_ad = 0; m_bd = 0; m_zd = 0; m_cnt = 0; m_err = 0;
      m_armed = 0; m_seen = 0; m_idx = 0; m_latch = 0;
      m_live = 1'b1;
    end else begin
      if (latch_req) m_latch = m_cnt;
      if (idx_arm_set) begin m_armed = 1; m_seen = 0; end
      else if (m_armed == 1 && m_f[2] == 1 && m_zd == 0) begin
        m_idx = m_cnt; m_seen = 1; m_armed = 0;
      end
      m_zd = m_f[2];
      if (m_f[0] != m_ad && m_f[1] != m_bd) m_err = 1;
      else if (m_f[0] != m_ad) m_cnt = (m_cnt + ((m_f[0] != m_f[1]) ? 1 : -1)) & MASK;
      else if (m_f[1] != m_bd) m_cnt = (m_cnt + ((m_f[0] == m_f[1]) ? 1 : -1)) & MASK;
      m_ad = m_f[0]; m_bd = m_f[1];
      for (int i = 0; i < 3; i++) begin
        if (m_s2[i] != m_f[i]) m_run[i]++; else m_run[i] = 0;
        if (m_run[i] == FL) begin m_f[i] = m_s2[i]; m_run[i] = 0; end
        m_s2[i] = m_s1[i];
        m_s1[i] = raw[i];
      end
    end
  end

  always @(negedge clk) begin
    if (m_live && rst_n && !finished) begin
      check("R5 model latch_count", latch_count, m_latch);
      check("R6 model idx_count", idx_count, m_idx);
      check("R6 model idx_seen", idx_seen, m_seen);
      check("R8 model idx_armed", idx_armed, m_armed);
      check("R4 model quad_err", quad_err, m_err);
    end
  end

  // ---------------- directed stimulus with an independent tally
  int g = 0;
  int exp_pos = 0;

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drive_g();
    qa_raw = (g == 1 || g == 2);
    qb_raw = (g == 2 || g == 3);
  endtask

  task automatic move(input int dir, input int hold);
    g = (dir > 0) ? ((g + 1) & 3) : ((g + 3) & 3);
    drive_g();
    exp_pos = (exp_pos + dir) & MASK;
    tick(hold);
  endtask

  task automatic do_latch(output int val);
    tick(4);
    latch_req = 1'b1; tick(1); latch_req = 1'b0; tick(1);
    val = latch_count;
  endtask

  task automatic arm();
    idx_arm_set = 1'b1; tick(1); idx_arm_set = 1'b0; tick(2);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      errors++; checks++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int v, l1, l2, hold_idx;
    tick(4);
    // R1 reset state
    check("R1 latch_count", latch_count, 0);
    check("R1 idx_count", idx_count, 0);
    check("R1 idx_seen", idx_seen, 0);
    check("R1 idx_armed", idx_armed, 0);
    check("R1 quad_err", quad_err, 0);
    rst_n = 1'b1;
    tick(2);
    do_latch(v); check("R1 count after reset", v, 0);

    // R7 wrap below zero, then back
    move(-1, 9); do_latch(v); check("R7 wrap down", v, 16383);
    move(1, 9);  do_latch(v); check("R7 wrap back", v, 0);

    // R3 direction
    for (int i = 0; i < 6; i++) move(1, 9);
    do_latch(v); check("R3 up run", v, exp_pos);
    for (int i = 0; i < 4; i++) move(-1, 9);
    do_latch(v); check("R3 down run", v, exp_pos);

    // R2 boundary: exactly seven samples per level passes
    for (int i = 0; i < 3; i++) move(1, 7);
    tick(6);
    do_latch(v); check("R2 seven-sample steps", v, exp_pos);
    // R2 six-sample glitch rejected
    qa_raw = ~qa_raw; tick(6); qa_raw = ~qa_raw; tick(12);
    do_latch(v); check("R2 glitch ignored", v, exp_pos);
    check("R2 glitch no error", quad_err, 0);

    // R4 invalid transition
    check("R4 error clear before", quad_err, 0);
    g = (g + 2) & 3; drive_g(); tick(9);
    do_latch(v); check("R4 count held", v, exp_pos);
    check("R4 error set", quad_err, 1);
    move(1, 9); tick(6);
    check("R4 error sticky", quad_err, 1);

    // R6 armed capture
    arm();
    check("R6 armed", idx_armed, 1);
    check("R6 seen cleared", idx_seen, 0);
    for (int i = 0; i < 3; i++) move(1, 9);
    tick(4);
    qz_raw = 1'b1; tick(6); qz_raw = 1'b0; tick(12);
    check("R2 index glitch ignored", idx_seen, 0);
    check("R2 index glitch still armed", idx_armed, 1);
    qz_raw = 1'b1; tick(12);
    hold_idx = exp_pos;
    check("R6 seen set", idx_seen, 1);
    check("R6 disarmed", idx_armed, 0);
    check("R6 captured count", idx_count, hold_idx);
    qz_raw = 1'b0; tick(12);
    move(1, 9); move(1, 9); tick(4);
    qz_raw = 1'b1; tick(12);
    check("R8 unarmed rise idx_count", idx_count, hold_idx);
    check("R8 unarmed rise seen", idx_seen, 1);
    // R8 falling edge while armed
    arm();
    check("R6 rearm clears seen", idx_seen, 0);
    move(-1, 9); tick(4);
    qz_raw = 1'b0; tick(12);
    check("R8 falling edge no capture", idx_seen, 0);
    check("R8 falling edge still armed", idx_armed, 1);
    check("R8 falling edge idx_count", idx_count, hold_idx);
    qz_raw = 1'b1; tick(12);
    check("R6 second capture", idx_count, exp_pos);
    check("R6 second seen", idx_seen, 1);
    qz_raw = 1'b0; tick(12);

    // R7 maximum resolvable delta
    do_latch(l1);
    for (int i = 0; i < 8191; i++) move(1, 8);
    do_latch(l2);
    check("R7 delta 8191", (l2 - l1) & MASK, 8191);
    check("R7 absolute", l2, exp_pos);

    tick(4);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule